// File: doc/BRIEF.md
# Data Access Watchpoint Checker

This block inspects each data memory access as it is presented: an address, a strobe and a flag that separates stores from loads. It does three things in sequence. First, it moves low addresses into the slot held by a process-ID register. Next, it checks the relocated address for word alignment. Last, it compares the relocated address against two programmable data-breakpoint registers. The comparison uses one of two modes. In the first, two independent comparators each match on a word address. In the second, a single comparator matches on a base value, and the second register acts as an inverse mask.

A misaligned access raises an abort pulse while alignment checking is on. A breakpoint hit raises a trap pulse. Both pulses are combinational, in the same cycle as the strobe. When the global debug-enable bit is set, a hit records an entry code in the debug status register. Under the same condition, an abort records a fault code and the faulting address. All eight registers share one write/read port, selected by a 3-bit index.

Top module: `data_watch_unit`

## Requirements
- R1: After reset every register reads as zero.
- R2: A write with `reg_wr` high stores `reg_wdata` in the register picked by `reg_sel`: 0 process ID, 1 control, 2 breakpoint control, 3 breakpoint 0, 4 breakpoint 1, 5 debug status, 6 fault status, 7 fault address. `reg_rdata` shows the selected register combinationally. A register write takes priority over any event update in the same cycle. Without a write, the configuration registers (selects 0 to 4) keep their values.
- R3: When process-ID bits 31:25 are nonzero and address bits 31:25 are all zero, `phys_addr` is the address ORed with those process-ID bits. Otherwise `phys_addr` equals the address. Every later check uses `phys_addr`.
- R4: `abort_o` is high in a cycle exactly when `acc_valid` is high, control bit 1 (alignment check) is set, and `phys_addr[1:0]` is nonzero.
- R5: Each comparator has a 2-bit enable code: 0 off, 1 stores only, 2 loads and stores, 3 loads only.
- R6: In normal mode (breakpoint control bit 8 clear), comparator 0 uses enable bits 1:0 and matches when `phys_addr[31:2]` equals breakpoint 0 bits 31:2. Comparator 1 uses enable bits 3:2 and matches in the same way against breakpoint 1.
- R7: In mask mode (breakpoint control bit 8 set), comparator 1 is ignored. Comparator 0 matches when `phys_addr` equals breakpoint 0 at every bit where breakpoint 1 holds a 0.
- R8: `trap_o` pulses with a valid access that hits. If debug status bit 31 is set, the next edge clears bits 4:2 and writes the code 3'b010 there.
- R9: With debug status bit 31 clear, a hit still raises `trap_o`, but the debug status register does not change.
- R10: `abort_o` takes priority: a misaligned access that aborts gives no trap. No pulse occurs while `acc_valid` is low.
- R11: If debug status bit 31 is set, an abort loads the fault status register with 1 and the fault address register with `phys_addr`. With bit 31 clear, or with no abort, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| phys_addr | output | AW | Address after process-ID relocation |
| abort_o | output | 1 | Alignment abort pulse |
| trap_o | output | 1 | Data-breakpoint trap pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Selected register contents |

## Verification
The bench builds the block with its defaults: a 32-bit address and a 7-bit process-ID slot. These values put the relocation boundary at bit 25. The stimulus can therefore cover both sides of that boundary. It can also reach mask patterns spanning the whole word, and the combination of relocation with a breakpoint on a relocated address. Word granularity and alignment are tied to bits 1:0, which the defaults leave fixed.

// File: rtl/data_watch_unit.sv
module data_watch_unit #(
  parameter int AW       = 32,
  parameter int PID_BITS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_store,
  output logic [AW-1:0] phys_addr,
  output logic          abort_o,
  output logic          trap_o,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata
);
  localparam int PID_LSB   = AW - PID_BITS;
  localparam int NREG      = 8;
  localparam int SEL_PID   = 0;
  localparam int SEL_CTRL  = 1;
  localparam int SEL_BPC   = 2;
  localparam int SEL_BP0   = 3;
  localparam int SEL_BP1   = 4;
  localparam int SEL_STAT  = 5;
  localparam int SEL_FSR   = 6;
  localparam int SEL_FAR   = 7;
  localparam int ALIGN_BIT = 1;
  localparam int MASK_BIT  = 8;
  localparam int DBG_EN    = 31;
  localparam logic [2:0] MOE_DBRK = 3'b010;
  localparam logic [AW-1:0] FSR_ALIGN = AW'(1);

  logic [AW-1:0] regs_q [NREG];

  wire [AW-1:0] pid  = regs_q[SEL_PID];
  wire [AW-1:0] ctrl = regs_q[SEL_CTRL];
  wire [AW-1:0] bpc  = regs_q[SEL_BPC];
  wire [AW-1:0] bp0  = regs_q[SEL_BP0];
  wire [AW-1:0] bp1  = regs_q[SEL_BP1];
  wire [AW-1:0] stat = regs_q[SEL_STAT];
  wire [AW-1:0] fsr  = regs_q[SEL_FSR];
  wire [AW-1:0] far  = regs_q[SEL_FAR];

  function automatic logic kind_ok(input logic [1:0] en, input logic st);
    return (en != 2'd0) && (st ? (en != 2'd3) : (en != 2'd1));
  endfunction

  wire relocate = (|pid[AW-1:PID_LSB]) && !(|acc_addr[AW-1:PID_LSB]);
  assign phys_addr = relocate ? (acc_addr | {pid[AW-1:PID_LSB], {PID_LSB{1'b0}}}) : acc_addr;

  wire mask_mode = bpc[MASK_BIT];
  wire hit0 = mask_mode ? (((phys_addr ^ bp0) & ~bp1) == '0)
                        : (phys_addr[AW-1:2] == bp0[AW-1:2]);
  wire hit1 = !mask_mode && (phys_addr[AW-1:2] == bp1[AW-1:2]);
  wire bp_hit = (hit0 && kind_ok(bpc[1:0], acc_store)) ||
                (hit1 && kind_ok(bpc[3:2], acc_store));

  assign abort_o = acc_valid && ctrl[ALIGN_BIT] && (phys_addr[1:0] != 2'b00);
  assign trap_o  = acc_valid && !abort_o && bp_hit;
  assign reg_rdata = regs_q[reg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (reg_wr) begin
      regs_q[reg_sel] <= reg_wdata;
    end else begin
      if (trap_o && stat[DBG_EN]) regs_q[SEL_STAT][4:2] <= MOE_DBRK;
      if (abort_o && stat[DBG_EN]) begin
        regs_q[SEL_FSR] <= FSR_ALIGN;
        regs_q[SEL_FAR] <= phys_addr;
      end
    end
  end

  AST_RELOC_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PID_LSB-1:0] == acc_addr[PID_LSB-1:0]); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(pid) && $stable(ctrl) && $stable(bpc) && $stable(bp0) && $stable(bp1))); // R2
  AST_MOE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && stat[DBG_EN] && !reg_wr) |=> (stat[4:2] == MOE_DBRK)); // R8
  AST_STAT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[DBG_EN] && !reg_wr) |=> $stable(stat)); // R9
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && stat[DBG_EN] && !reg_wr) |=> (far == $past(phys_addr) && fsr == FSR_ALIGN)); // R11
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_o && !reg_wr) |=> ($stable(fsr) && $stable(far))); // R11
endmodule

// File: tb/data_watch_unit_tb_top.sv
module data_watch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_store = 1'b0;
  logic [31:0] phys_addr;
  logic        abort_o, trap_o;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  data_watch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_store(acc_store), .phys_addr(phys_addr), .abort_o(abort_o), .trap_o(trap_o),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  typedef struct packed {
    logic [31:0] pid, ctrl, bpc, bp0, bp1, addr;
    logic        st, ab, tr;
    logic [31:0] phys;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0000_1000},
    '{32'hFE00_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 32'hFE00_1234},
    '{32'h0A00_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0200_0010, 1'b0, 1'b0, 1'b0, 32'h0200_0010},
    '{32'h0, 32'h2, 32'h0, 32'h0, 32'h0, 32'h0000_1002, 1'b0, 1'b1, 1'b0, 32'h0000_1002},
    '{32'h0, 32'h2, 32'h0, 32'h0, 32'h0, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 32'h0000_1004},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1002, 1'b0, 1'b0, 1'b0, 32'h0000_1002},
    '{32'h0, 32'h0, 32'h1, 32'h2000, 32'h0, 32'h0000_2003, 1'b1, 1'b0, 1'b1, 32'h0000_2003},
    '{32'h0, 32'h0, 32'h1, 32'h2000, 32'h0, 32'h0000_2003, 1'b0, 1'b0, 1'b0, 32'h0000_2003},
    '{32'h0, 32'h0, 32'h3, 32'h2000, 32'h0, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 32'h0000_2000},
    '{32'h0, 32'h0, 32'h3, 32'h2000, 32'h0, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 32'h0000_2000},
    '{32'h0, 32'h0, 32'h2, 32'h2000, 32'h0, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 32'h0000_2000},
    '{32'h0, 32'h0, 32'h2, 32'h2000, 32'h0, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 32'h0000_2000},
    '{32'h0, 32'h0, 32'h2, 32'h2000, 32'h0, 32'h0000_2004, 1'b0, 1'b0, 1'b0, 32'h0000_2004},
    '{32'h0, 32'h0, 32'h0, 32'h2000, 32'h0, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0000_2000},
    '{32'h0, 32'h0, 32'h8, 32'h0, 32'h3000, 32'h0000_3001, 1'b0, 1'b0, 1'b1, 32'h0000_3001},
    '{32'h0, 32'h0, 32'h4, 32'h0, 32'h3000, 32'h0000_3001, 1'b0, 1'b0, 1'b0, 32'h0000_3001},
    '{32'h0, 32'h0, 32'hC, 32'h0, 32'h3000, 32'h0000_3001, 1'b1, 1'b0, 1'b0, 32'h0000_3001},
    '{32'h0, 32'h0, 32'h102, 32'h4000, 32'h0FFF, 32'h0000_4ABC, 1'b0, 1'b0, 1'b1, 32'h0000_4ABC},
    '{32'h0, 32'h0, 32'h102, 32'h4000, 32'h0FFF, 32'h0000_5000, 1'b0, 1'b0, 1'b0, 32'h0000_5000},
    '{32'h0, 32'h0, 32'h10A, 32'h4000, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h0, 32'h2, 32'h2, 32'h2000, 32'h0, 32'h0000_2001, 1'b0, 1'b1, 1'b0, 32'h0000_2001},
    '{32'hFE00_0000, 32'h0, 32'h2, 32'hFE00_2000, 32'h0, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 32'hFE00_2000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input logic st, output logic ab, output logic tr, output logic [31:0] ph);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_store = st;
    #1;
    ab = abort_o; tr = trap_o; ph = phys_addr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ab, tr;
    logic [31:0] ph;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) rd_check("R1 reset value", 3'(s), 32'h0);

    for (int s = 0; s < 8; s++) begin
      wr(3'(s), 32'hA5A5_0000 + 32'(s));
    end
    for (int s = 0; s < 8; s++) rd_check("R2 readback", 3'(s), 32'hA5A5_0000 + 32'(s));
    for (int s = 0; s < 8; s++) wr(3'(s), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VECS[i].pid);
      wr(3'd1, VECS[i].ctrl);
      wr(3'd2, VECS[i].bpc);
      wr(3'd3, VECS[i].bp0);
      wr(3'd4, VECS[i].bp1);
      access(VECS[i].addr, VECS[i].st, ab, tr, ph);
      check($sformatf("R3 phys vec %0d", i), ph, VECS[i].phys);
      check($sformatf("R4 R10 abort vec %0d", i), 32'(ab), 32'(VECS[i].ab));
      check($sformatf("R5 R6 R7 trap vec %0d", i), 32'(tr), 32'(VECS[i].tr));
    end

    // R10: no pulse without strobe
    wr(3'd0, 32'h0); wr(3'd1, 32'h2); wr(3'd2, 32'h2); wr(3'd3, 32'h2000);
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h2001; acc_store = 1'b0;
    #1;
    check("R10 abort idle", 32'(abort_o), 32'h0);
    acc_addr = 32'h2000;
    #1;
    check("R10 trap idle", 32'(trap_o), 32'h0);
    wr(3'd1, 32'h0);

    // R8: entry code recorded, bits 4:2 cleared first
    wr(3'd5, 32'h8000_001C);
    access(32'h2000, 1'b0, ab, tr, ph);
    check("R8 trap", 32'(tr), 32'h1);
    rd_check("R8 status", 3'd5, 32'h8000_0008);

    // R9: disabled debug leaves status alone
    wr(3'd5, 32'h0000_001C);
    access(32'h2000, 1'b1, ab, tr, ph);
    check("R9 trap", 32'(tr), 32'h1);
    rd_check("R9 status", 3'd5, 32'h0000_001C);

    // R11: fault capture when enabled
    wr(3'd1, 32'h2); wr(3'd2, 32'h0);
    wr(3'd0, 32'hFE00_0000);
    wr(3'd5, 32'h8000_0000);
    access(32'h0000_1001, 1'b0, ab, tr, ph);
    check("R11 abort", 32'(ab), 32'h1);
    rd_check("R11 fsr", 3'd6, 32'h1);
    rd_check("R11 far", 3'd7, 32'hFE00_1001);

    // R11: held when disabled
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h55); wr(3'd7, 32'h77);
    access(32'h0000_3003, 1'b1, ab, tr, ph);
    check("R11 abort off", 32'(ab), 32'h1);
    rd_check("R11 fsr held", 3'd6, 32'h55);
    rd_check("R11 far held", 3'd7, 32'h77);

    // R11: aligned access does not touch fault registers
    wr(3'd5, 32'h8000_0000);
    access(32'h0000_3000, 1'b0, ab, tr, ph);
    rd_check("R11 fsr no abort", 3'd6, 32'h55);
    rd_check("R11 far no abort", 3'd7, 32'h77);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule